// File: doc/BRIEF.md
# Two-Port Register Address Pointer with Banked Layouts

This block keeps the byte address used by a serial register interface for a device with two 8-bit ports. It also turns that address into a register number and a port select. Each port owns eleven registers. A layout bit picks one of two maps:

- **Separated map:** port A registers sit low, and port B registers sit at a second base further up.
- **Interleaved map:** each register appears as an A/B pair, with A at the even address and B at the odd address.

A sequencing control decides what the pointer does after each data byte:

- **Sequencing on:** the pointer walks forward through the active map. It skips the gap between ports and wraps to zero at the end of the map.
- **Sequencing off:** the pointer either stays on one address (separated map) or swaps between the two halves of its pair (interleaved map).

The framing logic pulses `addr_load` with the address byte at the start of a transfer. It pulses `byte_done` after each data byte. The register file reads `reg_idx`, `reg_port_b` and `reg_hit` to select storage. When `reg_hit` is low the address lies outside the map, so reads return 00h and writes are dropped.

A three-state controller runs the pointer:

- `ST_IDLE` is the state after reset, before any address has been loaded.
- `ST_ADDRESSED` means an address has been loaded and no data byte has finished yet.
- `ST_STREAMING` means at least one data byte has finished.

The transitions are:

- **load** goes from any state to `ST_ADDRESSED`.
- **first byte** goes from `ST_ADDRESSED` to `ST_STREAMING`.
- **next byte** keeps `ST_STREAMING`.
- **idle byte** keeps `ST_IDLE` and leaves the pointer unchanged.

Top module: `gpx_addr_ptr`

## Requirements
- R1: After reset the pointer is 00h, the layout in force is interleaved, and the controller is idle. A `byte_done` seen while idle leaves the pointer at 00h.
- R2: An `addr_load` pulse puts `addr_byte` on `ptr` in the next cycle. If it comes in the same cycle as `byte_done`, the load wins.
- R3: In the separated layout (layout bit 1), addresses 00h–0Ah decode to port A and 10h–1Ah decode to port B. In both ranges the register number is the offset from the port base, in this order: 0 direction, 1 polarity, 2 interrupt enable, 3 compare value, 4 interrupt mode, 5 configuration, 6 pull-up, 7 interrupt flag, 8 capture, 9 port, 10 output latch.
- R4: In the interleaved layout (layout bit 0), addresses 00h–15h decode to register number address/2. Address bit 0 is the port select: 0 is A, 1 is B.
- R5: Any other address gives `reg_hit`=0, with `reg_idx`=0 and `reg_port_b`=0.
- R6: With sequencing on in the separated layout, each byte adds one to the pointer. The exceptions are that 0Ah steps to 10h, and 1Ah or anything above it steps to 00h.
- R7: With sequencing on in the interleaved layout, each byte adds one to the pointer, and 15h or anything above it steps to 00h.
- R8: With sequencing off in the separated layout, the pointer stays where it is after every byte.
- R9: With sequencing off in the interleaved layout, the pointer flips address bit 0 after every byte, whichever address of the pair it started on.
- R10: The layout bit is sampled only on an `addr_load` or `byte_done` pulse. The step made by a `byte_done` uses the layout that was in force before that pulse, and the new layout governs decoding from the next cycle on.
- R11: The shared configuration register (number 5) is found at 05h and 15h in the separated layout, and at 0Ah and 0Bh in the interleaved layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Strobe: load the pointer from `addr_byte` |
| addr_byte | input | AW | Address byte received from the framing logic |
| byte_done | input | 1 | Strobe: one data byte has completed |
| bank_sep | input | 1 | Layout bit: 1 selects separated, 0 selects interleaved |
| seq_off | input | 1 | 1 turns off sequential pointer advance |
| ptr | output | AW | Current pointer |
| reg_idx | output | IW | Decoded register number |
| reg_port_b | output | 1 | Decoded port select: 1 is port B |
| reg_hit | output | 1 | Address falls inside the active map |

## Verification
Directed sequences drive the pointer across both layout boundaries: the jump from 0Ah to 10h, the wraps from 1Ah and from 15h, and pair swapping that starts on an odd address. These separate a correct gap skip from a plain increment. Seeded random mixes of loads, data bytes and layout and sequencing flips, with most addresses drawn near the map and some anywhere in the byte range, test whether the layout is latched only on strobes. They also exercise out-of-map addresses and the rule that a load beats a simultaneous byte. A sweep over every configuration address in both layouts tells a real shared-register decode apart from a per-port one.

// File: rtl/gpx_ptr_pkg.sv
package gpx_ptr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ADDRESSED = 2'd1,
        ST_STREAMING = 2'd2
    } ptr_state_e;

    // Register numbers within one port, in map order.
    typedef enum logic [3:0] {
        RG_DIR   = 4'd0,
        RG_POL   = 4'd1,
        RG_IEN   = 4'd2,
        RG_CMP   = 4'd3,
        RG_IMODE = 4'd4,
        RG_CFG   = 4'd5,
        RG_PULL  = 4'd6,
        RG_IFLAG = 4'd7,
        RG_CAPT  = 4'd8,
        RG_PORT  = 4'd9,
        RG_LATCH = 4'd10
    } reg_name_e;

endpackage

// File: rtl/gpx_ptr_step.sv
// Computes the pointer value after one data byte.
module gpx_ptr_step #(
    parameter int AW     = 8,
    parameter int NREG   = 11,
    parameter int B_BASE = 16
) (
    input  logic [AW-1:0] cur,
    input  logic          bank_sep,
    input  logic          seq_off,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] LAST_A  = AW'(NREG - 1);
    localparam logic [AW-1:0] BASE_B  = AW'(B_BASE);
    localparam logic [AW-1:0] LAST_B  = AW'(B_BASE + NREG - 1);
    localparam logic [AW-1:0] LAST_IL = AW'(2 * NREG - 1);

    always_comb begin
        nxt = cur;
        if (seq_off) begin
            // separated: hold; interleaved: swap within the pair
            nxt = bank_sep ? cur : {cur[AW-1:1], ~cur[0]};
        end else if (bank_sep) begin
            if (cur == LAST_A)      nxt = BASE_B;
            else if (cur >= LAST_B) nxt = '0;
            else                    nxt = cur + AW'(1);
        end else begin
            if (cur >= LAST_IL)     nxt = '0;
            else                    nxt = cur + AW'(1);
        end
    end

endmodule

// File: rtl/gpx_ptr_decode.sv
// Maps a pointer value onto register number and port for the active layout.
module gpx_ptr_decode #(
    parameter int AW     = 8,
    parameter int NREG   = 11,
    parameter int B_BASE = 16,
    parameter int IW     = $clog2(NREG)
) (
    input  logic [AW-1:0] addr,
    input  logic          bank_sep,
    output logic [IW-1:0] idx,
    output logic          port_b,
    output logic          hit
);
    localparam logic [AW-1:0] LAST_A  = AW'(NREG - 1);
    localparam logic [AW-1:0] BASE_B  = AW'(B_BASE);
    localparam logic [AW-1:0] LAST_B  = AW'(B_BASE + NREG - 1);
    localparam logic [AW-1:0] LAST_IL = AW'(2 * NREG - 1);

    logic [AW-1:0] off_b;
    logic [AW-1:0] half;

    assign off_b = addr - BASE_B;
    assign half  = addr >> 1;

    always_comb begin
        idx    = '0;
        port_b = 1'b0;
        hit    = 1'b0;
        if (bank_sep) begin
            if (addr <= LAST_A) begin
                idx = addr[IW-1:0];
                hit = 1'b1;
            end else if (addr >= BASE_B && addr <= LAST_B) begin
                idx    = off_b[IW-1:0];
                port_b = 1'b1;
                hit    = 1'b1;
            end
        end else if (addr <= LAST_IL) begin
            idx    = half[IW-1:0];
            port_b = addr[0];
            hit    = 1'b1;
        end
    end

    // R5: a hit always names a register that exists
    always_comb begin
        if (hit) begin
            a_r5_idx_in_range: assert (int'(idx) < NREG)
                else $error("decoded register number out of range");
        end
    end

endmodule

// File: rtl/gpx_addr_ptr.sv
module gpx_addr_ptr
    import gpx_ptr_pkg::*;
#(
    parameter int AW     = 8,
    parameter int NREG   = 11,
    parameter int B_BASE = 16,
    parameter int IW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_byte,
    input  logic          byte_done,
    input  logic          bank_sep,
    input  logic          seq_off,
    output logic [AW-1:0] ptr,
    output logic [IW-1:0] reg_idx,
    output logic          reg_port_b,
    output logic          reg_hit
);
    localparam logic [AW-1:0] LAST_A = AW'(NREG - 1);
    localparam logic [AW-1:0] BASE_B = AW'(B_BASE);

    ptr_state_e    state, state_nx;
    logic          bank_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] step_val;
    logic          advance;

    // ---- state register ----
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---- transitions ----
    always_comb begin
        state_nx = state;
        advance  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (addr_load) state_nx = ST_ADDRESSED;     // load
            end
            ST_ADDRESSED: begin
                if (addr_load)      state_nx = ST_ADDRESSED; // load
                else if (byte_done) begin                    // first byte
                    state_nx = ST_STREAMING;
                    advance  = 1'b1;
                end
            end
            ST_STREAMING: begin
                if (addr_load)      state_nx = ST_ADDRESSED; // load
                else if (byte_done) advance  = 1'b1;         // next byte
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    gpx_ptr_step #(.AW(AW), .NREG(NREG), .B_BASE(B_BASE)) u_step (
        .cur      (ptr_q),
        .bank_sep (bank_q),
        .seq_off  (seq_off),
        .nxt      (step_val)
    );

    // ---- outputs: pointer and latched layout ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            bank_q <= 1'b0;
        end else begin
            if (addr_load)    ptr_q <= addr_byte;
            else if (advance) ptr_q <= step_val;
            if (addr_load || byte_done) bank_q <= bank_sep;
        end
    end

    gpx_ptr_decode #(.AW(AW), .NREG(NREG), .B_BASE(B_BASE), .IW(IW)) u_dec (
        .addr     (ptr_q),
        .bank_sep (bank_q),
        .idx      (reg_idx),
        .port_b   (reg_port_b),
        .hit      (reg_hit)
    );

    assign ptr = ptr_q;

    // ---- assertions ----
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (ptr_q == '0));

    a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (ptr_q == $past(addr_byte)));

    a_r6_port_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && bank_q && !seq_off && ptr_q == LAST_A) |=> (ptr_q == BASE_B));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && bank_q && seq_off) |=> $stable(ptr_q));

    a_r9_pair_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !bank_q && seq_off) |=> (ptr_q == ($past(ptr_q) ^ AW'(1))));

    a_r10_bank_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_load && !byte_done) |=> $stable(bank_q));

endmodule

// File: tb/sim_gpx_addr_ptr.sv
`timescale 1ns/1ps
module sim_gpx_addr_ptr;
    localparam int AW = 8;
    localparam int NREG = 11;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_byte = '0;
    logic          byte_done = 1'b0;
    logic          bank_sep = 1'b0;
    logic          seq_off = 1'b0;
    logic [AW-1:0] ptr;
    logic [IW-1:0] reg_idx;
    logic          reg_port_b;
    logic          reg_hit;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    // model state
    logic [7:0] m_ptr = '0;
    logic       m_bank = 1'b0;
    bit         m_loaded = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles++;

    gpx_addr_ptr #(.AW(AW), .NREG(NREG), .B_BASE(16), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_byte(addr_byte),
        .byte_done(byte_done), .bank_sep(bank_sep), .seq_off(seq_off),
        .ptr(ptr), .reg_idx(reg_idx), .reg_port_b(reg_port_b), .reg_hit(reg_hit)
    );

    function automatic logic [7:0] exp_next(input logic [7:0] p, input logic bk, input logic so);
        if (so) return bk ? p : (p ^ 8'h01);
        if (bk) begin
            if (p == 8'h0A) return 8'h10;
            if (p >= 8'h1A) return 8'h00;
            return p + 8'h01;
        end
        if (p >= 8'h15) return 8'h00;
        return p + 8'h01;
    endfunction

    // returns {hit, port_b, idx[3:0]}
    function automatic logic [5:0] exp_dec(input logic [7:0] p, input logic bk);
        if (bk) begin
            if (p <= 8'h0A) return {1'b1, 1'b0, p[3:0]};
            if (p >= 8'h10 && p <= 8'h1A) return {1'b1, 1'b1, 4'(p - 8'h10)};
            return 6'b0;
        end
        if (p <= 8'h15) return {1'b1, p[0], 4'(p >> 1)};
        return 6'b0;
    endfunction

    task automatic check_ptr(input string tag);
        checks++;
        if (ptr !== m_ptr) begin
            fails++;
            $display("FAIL %s ptr actual=%02h expected=%02h", tag, ptr, m_ptr);
        end
    endtask

    task automatic check_dec(input string tag);
        logic [5:0] e;
        e = exp_dec(m_ptr, m_bank);
        checks++;
        if ({reg_hit, reg_port_b, reg_idx} !== e) begin
            fails++;
            $display("FAIL %s decode actual=%b/%b/%0d expected=%b/%b/%0d (ptr=%02h bank=%b)",
                     tag, reg_hit, reg_port_b, reg_idx, e[5], e[4], e[3:0], m_ptr, m_bank);
        end
    endtask

    function automatic string dec_tag();
        if (exp_dec(m_ptr, m_bank) == 6'b0) return "R5";
        return m_bank ? "R3" : "R4";
    endfunction

    task automatic step(input logic ld, input logic [7:0] b, input logic dn,
                        input logic bk, input logic so);
        string t;
        @(negedge clk);
        addr_load = ld; addr_byte = b; byte_done = dn; bank_sep = bk; seq_off = so;
        if (ld)               t = "R2";
        else if (dn && !m_loaded) t = "R1";
        else if (dn)          t = m_bank ? (so ? "R8" : "R6") : (so ? "R9" : "R7");
        else                  t = "R10";
        @(posedge clk);
        #1;
        if (ld) begin
            m_ptr = b; m_loaded = 1;
        end else if (dn && m_loaded) begin
            m_ptr = exp_next(m_ptr, m_bank, so);
        end
        if (ld || dn) m_bank = bk;
        addr_load = 1'b0; byte_done = 1'b0;
        check_ptr(t);
        check_dec(dec_tag());
    endtask

    // watchdog
    initial begin
        wait (cycles > 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] cfg_a [4];
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check_ptr("R1");
        check_dec("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: byte while idle does not move pointer
        step(0, 8'h00, 1, 0, 0);
        step(0, 8'h00, 1, 1, 0);

        // R6: separated walk across gap and wrap
        step(1, 8'h09, 0, 1, 0);
        step(0, 8'h00, 1, 1, 0);   // 0A
        step(0, 8'h00, 1, 1, 0);   // 10
        step(1, 8'h19, 0, 1, 0);
        step(0, 8'h00, 1, 1, 0);   // 1A
        step(0, 8'h00, 1, 1, 0);   // 00
        step(1, 8'h0D, 0, 1, 0);   // out of map, R5
        step(0, 8'h00, 1, 1, 0);

        // R7: interleaved wrap
        step(1, 8'h14, 0, 0, 0);
        step(0, 8'h00, 1, 0, 0);   // 15
        step(0, 8'h00, 1, 0, 0);   // 00

        // R8: separated hold
        step(1, 8'h09, 0, 1, 1);
        repeat (3) step(0, 8'h00, 1, 1, 1);

        // R9: interleaved swap starting odd
        step(1, 8'h15, 0, 0, 1);
        repeat (3) step(0, 8'h00, 1, 0, 1);

        // R2: load beats byte in the same cycle
        step(1, 8'h03, 1, 0, 0);

        // R10: layout input changes without strobe have no effect
        step(1, 8'h0A, 0, 1, 0);
        step(0, 8'h00, 0, 0, 0);
        // byte with new layout: step uses old (separated) layout -> 10h, decode interleaved
        step(0, 8'h00, 1, 0, 0);

        // R11: configuration register location in both layouts
        cfg_a[0] = 8'h05; cfg_a[1] = 8'h15; cfg_a[2] = 8'h0A; cfg_a[3] = 8'h0B;
        for (int i = 0; i < 4; i++) begin
            step(1, cfg_a[i], 0, (i < 2), 1);
            checks++;
            if (reg_idx !== 4'(gpx_ptr_pkg::RG_CFG) || !reg_hit) begin
                fails++;
                $display("FAIL R11 cfg at %02h actual=%0d/%b expected=5/1",
                         cfg_a[i], reg_idx, reg_hit);
            end
        end

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            logic [7:0]  a;
            r = $urandom;
            a = (r[3:0] == 4'h0) ? 8'(r[31:24]) : {3'b000, r[28:24]};
            step(r[7:5] == 3'b000, a, r[9:8] != 2'b00, r[10], r[12:11] == 2'b00);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule